// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block models a synchronous static RAM whose controls and data are fully pipelined, so that reads and writes can be mixed on every clock without idle cycles. A cycle is started by pulling the load input low. On that edge the address, the three chip selects, the read/write input and the byte-write enables are sampled, and the cycle becomes a read, a write or a deselect. When the load input is high, a 2-bit burst counter produces the next address inside an aligned four-word block. It steps in either linear or interleaved order, and wraps after four accesses.

Read data reaches a registered output two active edges after the read address. Write data is taken two active edges after its address. Because both use the same pipeline slot, the shared data bus sees no gap when reads and writes follow each other. A read that overtakes a write whose data has just arrived gets the new bytes, merged lane by lane with the stored word. The block also has a clock-enable that freezes the whole pipeline, a sleep input that blocks new cycles and releases the output, and an asynchronous output enable.

Top module: `pipe_sram`

## Requirements
- R1: While `rst` is high on a clock edge, all pipeline stages, the burst state and the output-valid state clear, so `dq_en` is 0 after that edge.
- R2: A load edge (`ld_n`=0) counts as a deselect unless `sel0_n`=0, `sel1`=1 and `sel2_n`=0. A deselect writes nothing, and two edges later `dq_en` stays 0.
- R3: A read is a load edge N with `wr_n`=1. After active edge N+2, `dq` holds the word at that address and `dq_en` is 1, provided `oe_n`=0 and `sleep`=0.
- R4: A write is a load edge N with `wr_n`=0. Its byte enables are sampled at edge N and its data on `din` at active edge N+2. Lane i is bits [9i+8:9i], and it is written only when `bw_n[i]`=0.
- R5: With `order_lin`=1 sampled at the load edge, the advance edges (`ld_n`=1) address the low two bits base+1, base+2, base+3 modulo 4. The upper bits are unchanged and the cycle type is the one from the load.
- R6: With `order_lin`=0 at the load edge, advance k addresses the low two bits base XOR k.
- R7: The burst wraps: the fourth advance returns to the base address, and the block never leaves its aligned four-word group.
- R8: An edge with `cke_n`=1 changes nothing: no stage, counter, array word or output moves.
- R9: A read loaded on the edge right after a write to the same address returns that write's new bytes in its enabled lanes and the old bytes elsewhere.
- R10: While `sleep`=1, load and advance edges start no cycle and `dq_en` is 0. Writes already in the pipeline still take their data and complete, and stored words are kept.
- R11: `oe_n`=1 forces `dq_en` to 0 at once, without waiting for a clock edge.
- R12: Reads and writes can alternate on every active edge, and each completes with the latency in R3 and R4.
- R13: An advance edge that follows a deselect, a reset, or no load at all starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Active-low clock enable |
| ld_n | input | 1 | Low: load a new address; high: advance the burst |
| wr_n | input | 1 | At load: 1 read, 0 write |
| sel0_n | input | 1 | Active-low chip select |
| sel1 | input | 1 | Active-high chip select |
| sel2_n | input | 1 | Active-low chip select |
| bw_n | input | LANES | Active-low byte-lane write enables |
| addr | input | ADDR_W | Word address |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| sleep | input | 1 | Blocks new cycles and releases the output |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | LANES*LANE_W | Write data, two edges after the address |
| dq | output | LANES*LANE_W | Registered read data |
| dq_en | output | 1 | Output drive enable; 0 means high impedance |

## Verification
Two functions can land on the same edge: the array commits a write's late data while a read loaded one edge later samples the same word. The bench provokes this by loading a read of the just-written address on the very next edge, using both full and partial byte masks. It also does this inside back-to-back alternating traffic and in an interleaved burst of writes followed by reads. A behavioural reference model compares every cycle: it keeps a plain word array and a two-entry list of cycles in flight, and applies each write before any later read looks at the array. The same comparison judges bursts, deselects, freezes and sleep periods.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low two address bits for burst step k from a base
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] step,
                                           input logic       lin);
    return lin ? (base + step) : (base ^ step);
  endfunction
endpackage

// File: rtl/psram_ctrl.sv
// Cycle decode, burst counter and the two-slot op pipeline.
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int ADDR_W = 6,   // must be at least 3
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              ld_n,
  input  logic              wr_n,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              sleep,
  input  logic              order_lin,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bw_n,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_bw_n,
  output op_e               s2_op,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [LANES-1:0]  s2_bw_n
);
  localparam int HI_W = ADDR_W - 2;

  op_e               b_op;
  logic [ADDR_W-1:0] b_base;
  logic [1:0]        b_cnt;
  logic              b_lin;

  logic              selected;
  logic [1:0]        nxt_cnt;
  op_e               slot_op;
  logic [ADDR_W-1:0] slot_addr;

  always_comb begin
    selected  = !sel0_n && sel1 && !sel2_n;
    nxt_cnt   = b_cnt + 2'd1;
    slot_op   = OP_NONE;
    slot_addr = addr;
    if (!sleep) begin
      if (!ld_n) begin
        if (selected) slot_op = wr_n ? OP_RD : OP_WR;
      end else if (b_op != OP_NONE) begin
        slot_op   = b_op;
        slot_addr = {b_base[ADDR_W-1:2], burst_low(b_base[1:0], nxt_cnt, b_lin)};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_op    <= OP_NONE;
      b_base  <= '0;
      b_cnt   <= '0;
      b_lin   <= 1'b1;
      s1_op   <= OP_NONE;
      s2_op   <= OP_NONE;
      s1_addr <= '0;
      s2_addr <= '0;
      s1_bw_n <= '1;
      s2_bw_n <= '1;
    end else if (ce) begin
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_bw_n <= s1_bw_n;
      s1_op   <= slot_op;
      s1_addr <= slot_addr;
      s1_bw_n <= bw_n;
      if (!sleep) begin
        if (!ld_n) begin
          b_op   <= selected ? (wr_n ? OP_RD : OP_WR) : OP_NONE;
          b_base <= addr;
          b_cnt  <= 2'd0;
          b_lin  <= order_lin;
        end else if (b_op != OP_NONE) begin
          b_cnt <= nxt_cnt;
        end
      end
    end
  end

  // R2: a load without all three selects active yields an empty slot
  p_deselect_r2: assert property (@(posedge clk) disable iff (rst)
    (ce && !ld_n && !sleep && (sel0_n || !sel1 || sel2_n)) |=> (s1_op == OP_NONE));

  // R13: an advance with no open burst yields an empty slot
  p_no_type_on_advance_r13: assert property (@(posedge clk) disable iff (rst)
    (ce && ld_n && b_op == OP_NONE) |=> (s1_op == OP_NONE));

  // R10: sleep blocks new cycles
  p_sleep_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    (ce && sleep) |=> (s1_op == OP_NONE));

  // R7: burst addresses stay inside the aligned group of the base
  p_burst_group_r7: assert property (@(posedge clk) disable iff (rst)
    (ce && ld_n && !sleep && b_op != OP_NONE)
      |=> (s1_addr[ADDR_W-1:2] == $past(b_base[ADDR_W-1:2])));

  // R8: a disabled edge leaves the pipeline untouched
  p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (!ce && !rst) |=> ($stable(s1_op) && $stable(s2_op) && $stable(s1_addr)
                       && $stable(s2_addr) && $stable(b_cnt)));

  // R12: every active edge advances the slot pipeline by one
  p_slot_shift_r12: assert property (@(posedge clk) disable iff (rst)
    (ce && !rst) |=> (s2_op == $past(s1_op)));

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: rtl/psram_array.sv
// Storage: one RAM per byte lane, read-first, so each lane infers a block RAM.
module psram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    ce,
  input  logic                    we,
  input  logic [LANES-1:0]        wbe_n,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] ram [DEPTH];
    always_ff @(posedge clk) begin
      if (ce) begin
        if (we && !wbe_n[g]) ram[waddr] <= wdata[g*LANE_W +: LANE_W];
        rdata[g*LANE_W +: LANE_W] <= ram[raddr];
      end
    end
  end
endmodule

// File: rtl/psram_out.sv
// Late-write capture register, read merge and the registered output.
module psram_out
  import psram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce,
  input  op_e                     s2_op,
  input  logic [ADDR_W-1:0]       s2_addr,
  input  logic [LANES-1:0]        s2_bw_n,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic [LANES*LANE_W-1:0] raw,
  output logic [LANES*LANE_W-1:0] q,
  output logic                    q_vld
);
  localparam int DATA_W = LANES * LANE_W;

  logic              wl_vld;
  logic [ADDR_W-1:0] wl_addr;
  logic [LANES-1:0]  wl_bw_n;
  logic [DATA_W-1:0] wl_data;
  logic              hit;
  logic [DATA_W-1:0] merged;

  always_comb begin
    hit = wl_vld && (wl_addr == s2_addr);
    for (int i = 0; i < LANES; i++) begin
      merged[i*LANE_W +: LANE_W] = (hit && !wl_bw_n[i]) ? wl_data[i*LANE_W +: LANE_W]
                                                       : raw[i*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wl_vld  <= 1'b0;
      wl_addr <= '0;
      wl_bw_n <= '1;
      wl_data <= '0;
      q       <= '0;
      q_vld   <= 1'b0;
    end else if (ce) begin
      wl_vld  <= (s2_op == OP_WR);
      wl_addr <= s2_addr;
      wl_bw_n <= s2_bw_n;
      wl_data <= din;
      q_vld   <= (s2_op == OP_RD);
      if (s2_op == OP_RD) q <= merged;
    end
  end

  // R3: a read leaving the pipeline makes the output valid
  p_read_valid_r3: assert property (@(posedge clk) disable iff (rst)
    (ce && s2_op == OP_RD) |=> q_vld);

  // R9: a full-mask write committed one edge earlier reaches a read of its word
  p_forward_full_r9: assert property (@(posedge clk) disable iff (rst)
    (ce && s2_op == OP_RD && wl_vld && wl_addr == s2_addr && wl_bw_n == '0)
      |=> (q == $past(wl_data)));

  // R4: write data is captured only from the write slot
  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (ce && s2_op == OP_WR) |=> (wl_vld && wl_data == $past(din)));
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import psram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke_n,
  input  logic              ld_n,
  input  logic              wr_n,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              order_lin,
  input  logic              sleep,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dq,
  output logic              dq_en
);
  logic              ce;
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_bw_n, s2_bw_n;
  logic [DATA_W-1:0] raw, q;
  logic              q_vld;

  assign ce = !cke_n;

  psram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .ce(ce), .ld_n(ld_n), .wr_n(wr_n),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n), .sleep(sleep),
    .order_lin(order_lin), .addr(addr), .bw_n(bw_n),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_bw_n(s1_bw_n),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_bw_n(s2_bw_n)
  );

  psram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .ce(ce), .we(s2_op == OP_WR), .wbe_n(s2_bw_n),
    .waddr(s2_addr), .wdata(din), .raddr(s1_addr), .rdata(raw)
  );

  psram_out #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_out (
    .clk(clk), .rst(rst), .ce(ce), .s2_op(s2_op), .s2_addr(s2_addr),
    .s2_bw_n(s2_bw_n), .din(din), .raw(raw), .q(q), .q_vld(q_vld)
  );

  assign dq    = q;
  assign dq_en = q_vld && !oe_n && !sleep;

  // R1: reset releases the output
  p_reset_release_r1: assert property (@(posedge clk) rst |=> !dq_en);

  // R8: a disabled edge keeps the output register
  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cke_n && !rst) |=> ($stable(q) && $stable(q_vld)));
endmodule

// File: tb/pipe_sram_tb_top.sv
module pipe_sram_tb_top;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke_n = 1'b0, ld_n = 1'b1, wr_n = 1'b1;
  logic sel0_n = 1'b0, sel1 = 1'b1, sel2_n = 1'b0;
  logic [NL-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic order_lin = 1'b1, sleep = 1'b0, oe_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dq;
  logic dq_en;

  always #4 clk = ~clk;

  pipe_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
    .clk(clk), .rst(rst), .cke_n(cke_n), .ld_n(ld_n), .wr_n(wr_n),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n), .bw_n(bw_n), .addr(addr),
    .order_lin(order_lin), .sleep(sleep), .oe_n(oe_n), .din(din),
    .dq(dq), .dq_en(dq_en)
  );

  int n_chk = 0;
  int n_fail = 0;
  string req = "R1";

  // reference model: 0 none, 1 read, 2 write
  logic [DW-1:0] m_mem [DEPTH];
  int m_k1 = 0, m_k2 = 0;
  int m_a1 = 0, m_a2 = 0;
  logic [NL-1:0] m_b1 = '1, m_b2 = '1;
  int m_bop = 0, m_base = 0, m_cnt = 0;
  logic m_lin = 1'b1;
  logic [DW-1:0] m_q = '0;
  logic m_qv = 1'b0;
  logic [DW-1:0] dpipe [$];

  task automatic check(input bit ok, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int sk, sa;
    if (rst) begin
      m_k1 = 0; m_k2 = 0; m_bop = 0; m_qv = 1'b0; m_q = '0;
      return;
    end
    if (cke_n) return;
    if (m_k2 == 2)
      for (int i = 0; i < NL; i++)
        if (!m_b2[i]) m_mem[m_a2][i*LW +: LW] = din[i*LW +: LW];
    m_qv = (m_k2 == 1);
    if (m_k2 == 1) m_q = m_mem[m_a2];
    sk = 0; sa = addr;
    if (!sleep) begin
      if (!ld_n) begin
        if (!sel0_n && sel1 && !sel2_n) sk = wr_n ? 1 : 2;
        m_bop = sk; m_base = addr; m_cnt = 0; m_lin = order_lin;
      end else if (m_bop != 0) begin
        m_cnt = (m_cnt + 1) % 4;
        sk = m_bop;
        sa = (m_base & ~3) | (m_lin ? ((m_base + m_cnt) & 3) : ((m_base & 3) ^ m_cnt));
      end
    end
    m_k2 = m_k1; m_a2 = m_a1; m_b2 = m_b1;
    m_k1 = sk;   m_a1 = sa;   m_b1 = bw_n;
  endtask

  task automatic compare();
    logic e_en;
    e_en = m_qv && !oe_n && !sleep;
    check(dq_en == e_en, "dq_en", {35'd0, dq_en}, {35'd0, e_en});
    if (e_en) check(dq == m_q, "dq", dq, m_q);
  endtask

  // one clock: l=ld_n, w=wr_n, a=addr, b=bw_n, wd=data owed two active edges later
  task automatic cyc(input logic l, input logic w, input int a,
                     input logic [NL-1:0] b, input logic [DW-1:0] wd);
    ld_n = l; wr_n = w; addr = AW'(a); bw_n = b;
    if (rst) dpipe.delete();
    else if (!cke_n) begin
      dpipe.push_back(wd);
      if (dpipe.size() > 2) din = dpipe.pop_front();
      else din = '0;
    end
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 0, '1, '0);
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return {9'(a * 3 + s), 9'(a + 5 + s), 9'(a ^ s), 9'(a + 100 + s)};
  endfunction

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired (%s): actual running expected done", req);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    // R1: reset
    req = "R1";
    rst = 1'b1;
    cyc(1'b0, 1'b1, 3, '1, '0);
    cyc(1'b0, 1'b1, 3, '1, '0);
    rst = 1'b0;
    check(dq_en == 1'b0, "dq_en after reset", {35'd0, dq_en}, '0);
    // R13: advance without any load starts nothing
    req = "R13";
    idle(3);

    // R4 / R12: fill the array with back-to-back full writes
    req = "R4";
    for (int i = 0; i < DEPTH; i++) cyc(1'b0, 1'b0, i, 4'b0000, pat(i, 0));
    idle(2);
    // R3: back-to-back reads
    req = "R3";
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, i * 7 % DEPTH, '1, '0);
    idle(2);

    // R4: partial writes, lanes 0 and 2 (bw_n=1010), then lane 3 only
    req = "R4";
    cyc(1'b0, 1'b0, 20, 4'b1010, pat(20, 9));
    cyc(1'b0, 1'b0, 21, 4'b0111, pat(21, 4));
    idle(2);
    cyc(1'b0, 1'b1, 20, '1, '0);
    cyc(1'b0, 1'b1, 21, '1, '0);
    idle(2);

    // R9: read right after write to the same word, full and partial masks
    req = "R9";
    cyc(1'b0, 1'b0, 30, 4'b0000, pat(30, 2));
    cyc(1'b0, 1'b1, 30, '1, '0);
    idle(1);
    cyc(1'b0, 1'b0, 31, 4'b0101, pat(31, 6));
    cyc(1'b0, 1'b1, 31, '1, '0);
    idle(2);

    // R12: alternating writes and reads on every edge
    req = "R12";
    for (int i = 0; i < 10; i++) begin
      cyc(1'b0, 1'b0, 40 + i % 3, 4'(i), pat(40 + i, i));
      cyc(1'b0, 1'b1, 40 + (i + 1) % 3, '1, '0);
    end
    idle(2);

    // R5 / R7: linear read burst from base 5, six advances (wraps)
    req = "R5";
    order_lin = 1'b1;
    cyc(1'b0, 1'b1, 5, '1, '0);
    req = "R7";
    idle(6);
    // R6: interleaved read burst from base 14
    req = "R6";
    order_lin = 1'b0;
    cyc(1'b0, 1'b1, 14, '1, '0);
    idle(4);
    // R6 / R9: interleaved write burst then immediate read burst of the same group
    cyc(1'b0, 1'b0, 25, 4'b0000, pat(25, 11));
    for (int k = 1; k < 4; k++) cyc(1'b1, 1'b1, 0, 4'b0000, pat(25, 11 + k));
    cyc(1'b0, 1'b1, 25, '1, '0);
    idle(5);
    order_lin = 1'b1;

    // R2: deselected write with each select inactive in turn
    req = "R2";
    sel1 = 1'b0; cyc(1'b0, 1'b0, 50, 4'b0000, pat(0, 77));
    sel1 = 1'b1; sel0_n = 1'b1; cyc(1'b0, 1'b0, 50, 4'b0000, pat(1, 77));
    sel0_n = 1'b0; sel2_n = 1'b1; cyc(1'b0, 1'b1, 50, '1, '0);
    sel2_n = 1'b0;
    // R13: advances after the deselect start nothing
    req = "R13";
    idle(3);
    req = "R2";
    cyc(1'b0, 1'b1, 50, '1, '0);
    idle(2);

    // R8: freeze in the middle of a write and a read burst
    req = "R8";
    cyc(1'b0, 1'b0, 60, 4'b0000, pat(60, 3));
    cke_n = 1'b1;
    cyc(1'b0, 1'b1, 61, '1, '0);
    cyc(1'b0, 1'b0, 62, '1, '0);
    cke_n = 1'b0;
    cyc(1'b0, 1'b1, 60, '1, '0);
    cyc(1'b1, 1'b1, 0, '1, '0);
    cke_n = 1'b1;
    idle(3);
    cke_n = 1'b0;
    idle(4);

    // R10: sleep after a write; write completes, loads ignored, output released
    req = "R10";
    cyc(1'b0, 1'b0, 33, 4'b0000, pat(33, 8));
    cyc(1'b0, 1'b1, 9, '1, '0);
    sleep = 1'b1;
    cyc(1'b0, 1'b0, 34, 4'b0000, pat(34, 8));
    cyc(1'b0, 1'b1, 33, '1, '0);
    cyc(1'b1, 1'b1, 0, '1, '0);
    sleep = 1'b0;
    idle(2);
    cyc(1'b0, 1'b1, 33, '1, '0);
    cyc(1'b0, 1'b1, 34, '1, '0);
    idle(2);

    // R11: output enable acts without a clock edge
    req = "R11";
    cyc(1'b0, 1'b1, 12, '1, '0);
    idle(2);
    #1 oe_n = 1'b1;
    #1 check(dq_en == 1'b0, "dq_en with oe_n high", {35'd0, dq_en}, '0);
    oe_n = 1'b0;
    #1 check(dq_en == 1'b1, "dq_en with oe_n low", {35'd0, dq_en}, 36'd1);
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule